// File: doc/BRIEF.md
# Multiplexed LCD Scan Driver

This block scans a multiplexed liquid-crystal panel with 40 segment lines and up to four common lines. Each tick of a slow LCD clock starts one scan phase. At the start of the phase the driver reads the whole 20-byte display window of a synchronous RAM through a simple read port. When the last byte has arrived, it updates the common and segment level codes in a single clock edge. A separate analog stage turns those codes into bias voltages, so the panel never shows a mix of old and new contents.

A 2-bit duty code sets how many commons the scan cycles through: two, three or four. Commons beyond that count float as high impedance. Each display byte serves two neighbouring segments. The low nibble belongs to the even segment and the high nibble to the odd one, one bit per common. A frame-polarity output flips at every frame boundary so the bias stage can alternate drive polarity and keep the average voltage free of DC. When the driver is disabled or the duty code is invalid, it parks every line at the reset level.

Top module: `lcd_mux_driver`

## Requirements
- R1: After synchronous reset, every common and segment code is 00 (reset level), `ram_re` is 0 and `frame_pol` is 0.
- R2: If `lcd_en` is 0 or `duty_sel` is 00 at a clock edge, every code becomes 00 and `frame_pol` becomes 0 after that edge. Any fetch in progress is abandoned, and ticks start no reads.
- R3: An accepted tick makes `ram_re` high for exactly 20 consecutive cycles, starting in the cycle after the tick edge. During those cycles `ram_addr` steps upward from 0x40 to 0x53, one address per cycle. The RAM returns data one cycle after the address.
- R4: The codes and `frame_pol` change only at the 22nd clock edge after an accepted tick edge.
- R5: The number of commons in use is set by the duty code: 01 gives 2, 10 gives 3, 11 gives 4. Common codes are 01 (select) on the common of the current phase, 10 (non-select) on the other commons in use, and 11 (high-Z) on commons whose index is at or above the count in use.
- R6: Segment s takes code 01 when bit ((s mod 2)·4 + phase) of the byte at address 0x40 + s/2 is set, and code 10 otherwise.
- R7: The first phase shown after the driver becomes active is 0. Each later phase is the previous one plus 1, wrapping to 0 once the next value would reach the count in use.
- R8: `frame_pol` is 0 for the first frame. It inverts at every later update that returns to phase 0, and holds at all other updates.
- R9: Each byte is taken as it stands in the cycle it is read. A RAM write after that read has no effect on the outputs until the next fetch.
- R10: A tick at any of the 22 edges after an accepted tick edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_tick | input | 1 | One-cycle pulse starting a scan phase |
| lcd_en | input | 1 | Driver enable |
| duty_sel | input | 2 | Number of commons in use (01/10/11 = 2/3/4, 00 invalid) |
| ram_rdata | input | 8 | Display RAM read data, valid one cycle after address |
| ram_re | output | 1 | Display RAM read strobe |
| ram_addr | output | 8 | Display RAM read address |
| com_lvl | output | 8 | Two-bit level code per common, common c in bits 2c+1:2c |
| seg_lvl | output | 80 | Two-bit level code per segment, segment s in bits 2s+1:2s |
| frame_pol | output | 1 | Drive polarity of the current frame |

## Verification
The hardest case to reach from the ports is a display write that lands in the middle of a fetch. Bytes already read must keep their old value and bytes not yet read must pick up the new one, so the result depends on the exact cycle of the write. The stimulus writes two bytes ten cycles after a tick, one on each side of the read pointer. It also spaces ticks at random, closer and farther apart than the fetch length, so some fall into the ignore window. A reference model compares every output against a snapshot it takes cycle by cycle.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    LV_RST  = 2'b00,
    LV_SEL  = 2'b01,
    LV_NSEL = 2'b10,
    LV_HIZ  = 2'b11
  } lvl_t;

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int NCOM = 4,
  parameter int PH_W = $clog2(NCOM),
  parameter int NC_W = $clog2(NCOM + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            accept,
  input  logic            commit,
  input  logic [1:0]      duty,
  output logic [PH_W-1:0] lat_phase,
  output logic [NC_W-1:0] lat_ncom,
  output logic            frame_pol
);

  logic            live;
  logic [PH_W-1:0] cur_phase;
  logic [NC_W-1:0] cur_ncom;
  logic            cur_pol;
  logic            lat_pol;

  logic [NC_W-1:0] req_ncom;
  logic [NC_W-1:0] inc;
  logic            wrap;
  logic [PH_W-1:0] nxt_phase;
  logic            nxt_pol;

  assign req_ncom = NC_W'(duty) + NC_W'(1);
  assign inc      = NC_W'(cur_phase) + NC_W'(1);
  assign wrap     = (inc >= req_ncom);

  always_comb begin
    if (!live) begin
      nxt_phase = '0;
      nxt_pol   = 1'b0;
    end else begin
      nxt_phase = wrap ? '0 : inc[PH_W-1:0];
      nxt_pol   = wrap ? ~cur_pol : cur_pol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      live      <= 1'b0;
      cur_phase <= '0;
      cur_ncom  <= '0;
      cur_pol   <= 1'b0;
      lat_phase <= '0;
      lat_ncom  <= '0;
      lat_pol   <= 1'b0;
    end else begin
      if (accept) begin
        lat_phase <= nxt_phase;
        lat_ncom  <= req_ncom;
        lat_pol   <= nxt_pol;
      end
      if (commit) begin
        live      <= 1'b1;
        cur_phase <= lat_phase;
        cur_ncom  <= lat_ncom;
        cur_pol   <= lat_pol;
      end
    end
  end

  assign frame_pol = cur_pol;

  // R7: the shown phase never reaches the common count it was scheduled with
  a_r7_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    live |-> (NC_W'(cur_phase) < cur_ncom));

  // R8: a later frame that restarts at phase 0 flips the polarity
  a_r8_pol_flip: assert property (@(posedge clk) disable iff (rst)
    (commit && run && live && lat_phase == '0) |=> (cur_pol != $past(cur_pol)));

endmodule

// File: rtl/lcd_fetch.sv
module lcd_fetch #(
  parameter int             NBYTE  = 20,
  parameter int             BYTE_W = 8,
  parameter int             ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    start_req,
  input  logic [BYTE_W-1:0]       ram_rdata,
  output logic                    ram_re,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic                    accept,
  output logic                    commit,
  output logic [NBYTE*BYTE_W-1:0] stage_flat
);

  localparam int IW = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam logic [IW-1:0] LAST = IW'(NBYTE - 1);

  logic [IW-1:0]     cnt;
  logic              cap_v;
  logic [IW-1:0]     cap_i;
  logic              busy;
  logic [BYTE_W-1:0] stage_mem [NBYTE];

  assign busy   = ram_re | cap_v | commit;
  assign accept = start_req & run & ~busy;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ram_re   <= 1'b0;
      ram_addr <= BASE;
      cnt      <= '0;
      cap_v    <= 1'b0;
      cap_i    <= '0;
      commit   <= 1'b0;
    end else begin
      cap_v  <= ram_re;
      cap_i  <= cnt;
      commit <= cap_v && (cap_i == LAST);
      if (accept) begin
        ram_re   <= 1'b1;
        ram_addr <= BASE;
        cnt      <= '0;
      end else if (ram_re) begin
        if (cnt == LAST) begin
          ram_re <= 1'b0;
        end else begin
          cnt      <= cnt + IW'(1);
          ram_addr <= ram_addr + ADDR_W'(1);
        end
      end
    end
  end

  // single write port, one byte per cycle
  always_ff @(posedge clk) begin
    if (cap_v && run) stage_mem[cap_i] <= ram_rdata;
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_flat
    assign stage_flat[b*BYTE_W +: BYTE_W] = stage_mem[b];
  end

  // R3: reads within one fetch walk upward one address per cycle
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ram_re && $past(ram_re)) |-> (ram_addr == $past(ram_addr) + ADDR_W'(1)));

  // R3: every fetch opens at the window base
  a_r3_first_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_re) |-> (ram_addr == BASE));

  // R10: a fetch only begins from an idle engine
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_re) |-> !$past(busy));

  // R4: the update pulse never overlaps reading
  a_r4_commit_after_reads: assert property (@(posedge clk) disable iff (rst)
    commit |-> !ram_re);

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_pkg::*;
#(
  parameter int NSEG = 40,
  parameter int NCOM = 4,
  parameter int PH_W = $clog2(NCOM),
  parameter int NC_W = $clog2(NCOM + 1),
  parameter int BYTE_W = 2 * NCOM
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic                       commit,
  input  logic [PH_W-1:0]            phase,
  input  logic [NC_W-1:0]            ncom,
  input  logic [(NSEG/2)*BYTE_W-1:0] stage_flat,
  output logic [2*NCOM-1:0]          com_lvl,
  output logic [2*NSEG-1:0]          seg_lvl
);

  logic [2*NCOM-1:0] com_n;
  logic [2*NSEG-1:0] seg_n;
  logic [NCOM-1:0]   com_is_sel;

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_n[2*c +: 2] = (NC_W'(c) >= ncom)  ? LV_HIZ :
                             (phase == PH_W'(c)) ? LV_SEL : LV_NSEL;
    assign com_is_sel[c]   = (com_lvl[2*c +: 2] == LV_SEL);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [NCOM-1:0] nib;
    assign nib = stage_flat[(s/2)*BYTE_W + (s%2)*NCOM +: NCOM];
    assign seg_n[2*s +: 2] = nib[phase] ? LV_SEL : LV_NSEL;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      com_lvl <= '0;
      seg_lvl <= '0;
    end else if (commit) begin
      com_lvl <= com_n;
      seg_lvl <= seg_n;
    end
  end

  // R5: at most one common is selected at any time
  a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(com_is_sel));

  // R2: a cycle without a valid setting leaves every line at reset level
  a_r2_park: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> (com_lvl == '0 && seg_lvl == '0));

  // R4: outputs hold between update pulses
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !$past(commit)) |-> ($stable(com_lvl) && $stable(seg_lvl)));

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver #(
  parameter int NSEG   = 40,
  parameter int NCOM   = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40,
  parameter int PH_W   = $clog2(NCOM),
  parameter int NC_W   = $clog2(NCOM + 1),
  parameter int BYTE_W = 2 * NCOM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lcd_tick,
  input  logic              lcd_en,
  input  logic [1:0]        duty_sel,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic              frame_pol
);

  localparam int NBYTE = NSEG / 2;

  logic                    run;
  logic                    accept;
  logic                    commit;
  logic [PH_W-1:0]         lat_phase;
  logic [NC_W-1:0]         lat_ncom;
  logic [NBYTE*BYTE_W-1:0] stage_flat;

  assign run = lcd_en && (duty_sel != 2'b00);

  lcd_fetch #(
    .NBYTE(NBYTE), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_fetch (
    .clk(clk), .rst(rst), .run(run), .start_req(lcd_tick),
    .ram_rdata(ram_rdata), .ram_re(ram_re), .ram_addr(ram_addr),
    .accept(accept), .commit(commit), .stage_flat(stage_flat)
  );

  lcd_phase_seq #(
    .NCOM(NCOM), .PH_W(PH_W), .NC_W(NC_W)
  ) u_seq (
    .clk(clk), .rst(rst), .run(run), .accept(accept), .commit(commit),
    .duty(duty_sel), .lat_phase(lat_phase), .lat_ncom(lat_ncom),
    .frame_pol(frame_pol)
  );

  lcd_level_map #(
    .NSEG(NSEG), .NCOM(NCOM), .PH_W(PH_W), .NC_W(NC_W), .BYTE_W(BYTE_W)
  ) u_map (
    .clk(clk), .rst(rst), .run(run), .commit(commit), .phase(lat_phase),
    .ncom(lat_ncom), .stage_flat(stage_flat), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl)
  );

endmodule

// File: tb/tb_lcd_mux_driver.sv
module tb_lcd_mux_driver;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  duty = 2'b00;
  logic [7:0]  ram_rdata = 8'h00;
  logic        ram_re;
  logic [7:0]  ram_addr;
  logic [7:0]  com_lvl;
  logic [79:0] seg_lvl;
  logic        frame_pol;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [20];

  always #10 clk = ~clk;

  lcd_mux_driver dut (
    .clk(clk), .rst(rst), .lcd_tick(tick), .lcd_en(en), .duty_sel(duty),
    .ram_rdata(ram_rdata), .ram_re(ram_re), .ram_addr(ram_addr),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_pol(frame_pol)
  );

  // display RAM, one cycle read latency
  always @(posedge clk) begin
    if (ram_re) begin
      if (ram_addr >= 8'h40 && ram_addr < 8'h54) ram_rdata <= mem[ram_addr - 8'h40];
      else ram_rdata <= 8'h00;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int         m_cnt = -1;
  bit         m_live = 0;
  int         m_ph = 0;
  bit         m_pol = 0;
  int         m_nc = 0;
  int         l_ph = 0;
  bit         l_pol = 0;
  logic [7:0] snap [20];
  logic [7:0]  e_com = '0;
  logic [79:0] e_seg = '0;
  bit         e_pol = 0;
  bit         e_re = 0;
  logic [7:0] e_addr = 8'h40;
  bit         cmp_on = 0;

  always @(posedge clk) begin
    if (rst || !(en && duty != 2'b00)) begin
      m_cnt = -1; m_live = 0; m_ph = 0; m_pol = 0;
      e_com = '0; e_seg = '0; e_pol = 0; e_re = 0;
    end else begin
      if (m_cnt >= 0) begin
        m_cnt++;
        if (m_cnt >= 1 && m_cnt <= 20) snap[m_cnt-1] = mem[m_cnt-1];
        if (m_cnt == 22) begin
          m_ph = l_ph; m_pol = l_pol; m_live = 1; e_pol = l_pol;
          for (int c = 0; c < 4; c++)
            e_com[2*c +: 2] = (c >= m_nc) ? 2'b11 : (c == m_ph) ? 2'b01 : 2'b10;
          for (int s = 0; s < 40; s++)
            e_seg[2*s +: 2] = snap[s/2][(s%2)*4 + m_ph] ? 2'b01 : 2'b10;
          m_cnt = -1;
        end
      end else if (tick) begin
        m_cnt = 0;
        m_nc = int'(duty) + 1;
        if (!m_live) begin
          l_ph = 0; l_pol = 0;
        end else begin
          l_ph = (m_ph + 1 >= m_nc) ? 0 : m_ph + 1;
          l_pol = (l_ph == 0) ? !m_pol : m_pol;
        end
      end
      e_re = (m_cnt >= 0 && m_cnt <= 19);
      e_addr = 8'h40 + 8'(m_cnt);
    end
  end

  always @(negedge clk) begin
    if (!rst && cmp_on) begin
      chk("R5 R7 common codes", 128'(com_lvl), 128'(e_com));
      chk("R6 R9 segment codes", 128'(seg_lvl), 128'(e_seg));
      chk("R8 frame polarity", 128'(frame_pol), 128'(e_pol));
      chk("R3 read strobe", 128'(ram_re), 128'(e_re));
      if (e_re) chk("R3 read address", 128'(ram_addr), 128'(e_addr));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  function automatic int sel_com();
    for (int c = 0; c < 4; c++) if (com_lvl[2*c +: 2] == 2'b01) return c;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int ph;
    logic [7:0] old3;
    logic [7:0] old15;
    for (int i = 0; i < 20; i++) mem[i] = 8'(i * 37 + 11);
    cyc(3);
    @(negedge clk) rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk("R1 com after reset", 128'(com_lvl), 128'(0));
    chk("R1 seg after reset", 128'(seg_lvl), 128'(0));
    chk("R1 read strobe after reset", 128'(ram_re), 128'(0));
    chk("R1 polarity after reset", 128'(frame_pol), 128'(0));
    cmp_on = 1;

    // R4 latency from the first tick
    en = 1'b1; duty = 2'b11;
    pulse();
    n = 0;
    while (com_lvl == '0 && n < 60) begin
      @(negedge clk); n++;
    end
    chk("R4 tick-to-update edges", 128'(n), 128'(22));
    chk("R7 first phase after enable", 128'(sel_com()), 128'(0));
    cyc(5);

    // R7 R8 full cycles at four commons
    for (int k = 0; k < 9; k++) begin pulse(); cyc(28); end

    // R10 ticks inside the busy window
    pulse(); cyc(4); pulse(); cyc(13); pulse();
    cyc(40);
    n = 0;
    pulse();
    for (int k = 0; k < 30; k++) begin
      if (k == 6 || k == 19) tick = 1'b1; else tick = 1'b0;
      @(negedge clk);
      if (ram_re) n++;
    end
    tick = 1'b0;
    chk("R10 reads per accepted tick", 128'(n), 128'(19));
    cyc(10);

    // R9 writes landing mid-fetch
    old3 = mem[3]; old15 = mem[15];
    pulse();
    cyc(9);
    mem[3] = ~old3; mem[15] = ~old15;
    cyc(20);
    ph = sel_com();
    chk("R9 seg6 keeps old byte", 128'(seg_lvl[13:12]), 128'(old3[ph] ? 2'b01 : 2'b10));
    chk("R9 seg31 takes new byte", 128'(seg_lvl[63:62]), 128'(mem[15][4+ph] ? 2'b01 : 2'b10));

    // R5 two and three commons
    duty = 2'b01;
    for (int k = 0; k < 5; k++) begin pulse(); cyc(26); end
    chk("R5 unused commons high-Z at two", 128'(com_lvl[7:4]), 128'(4'b1111));
    duty = 2'b10;
    for (int k = 0; k < 5; k++) begin pulse(); cyc(26); end
    chk("R5 unused common high-Z at three", 128'(com_lvl[7:6]), 128'(2'b11));

    // R2 invalid duty code parks everything
    duty = 2'b00;
    cyc(1);
    chk("R2 com parked", 128'(com_lvl), 128'(0));
    chk("R2 seg parked", 128'(seg_lvl), 128'(0));
    chk("R2 polarity parked", 128'(frame_pol), 128'(0));
    n = 0;
    pulse();
    for (int k = 0; k < 25; k++) begin @(negedge clk); if (ram_re) n++; end
    chk("R2 no reads while invalid", 128'(n), 128'(0));

    // R2 enable dropped mid-fetch
    duty = 2'b11;
    pulse(); cyc(8);
    en = 1'b0;
    cyc(1);
    chk("R2 read aborted", 128'(ram_re), 128'(0));
    chk("R2 com parked on disable", 128'(com_lvl), 128'(0));
    en = 1'b1;

    // R6 random contents, duties and spacing
    for (int k = 0; k < 120; k++) begin
      if (k % 8 == 0) duty = 2'(1 + ($urandom % 3));
      mem[$urandom % 20] = 8'($urandom);
      pulse();
      cyc(8 + ($urandom % 30));
    end
    cyc(30);
    chk("R6 R8 run ended parked-free", 128'(com_lvl != '0), 128'(1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule